// File: doc/BRIEF.md
# Static Memory Bank Access Controller

This block connects a simple internal request port to one bank of asynchronous static memory. A request carries a byte address, up to 32 bits of right-aligned write data, per-byte enables, a transfer size and a direction. The block drives chip select, output enable, write enable and four active-low byte lane strobes. It holds each external access for a programmable number of wait states. For a read it returns the assembled data together with a one-cycle done pulse.

An 8-bit configuration word selects the behaviour. It sets the bank width, the chip select polarity and the lane strobe mode, and it switches page-mode read bursts and one long shared wait count on or off. A request wider than the bank is split into two or four external accesses in ascending address order. Chip select stays asserted across all of these accesses. Read bytes are packed little-endian, with request byte j taken from bank address `req_addr + j`.

Configuration word layout: bits [1:0] width (00 = 8-bit, 01 = 16-bit, 10 = 32-bit, 11 reserved), bit 2 chip select active high, bit 3 lane strobe mode, bit 4 page mode, bit 5 extended wait, bits [7:6] reserved. Request size: 0 = byte, 1 = halfword, 2 = word. Requests are aligned to their size.

Top module: `sram_bank_ctrl`

## Requirements
- R1: A request of S bytes (1, 2 or 4) to a bank of B bytes (1, 2 or 4, from width codes 00, 01, 10) uses max(1, S/B) external accesses. The accesses go in ascending address order, each at `req_addr + i*B`. Read data is little-endian: request byte j is the memory byte at `req_addr + j`, and result bytes at index S and above read as zero.
- R2: Chip select is high while active when config bit 2 is 1, and low while active when bit 2 is 0.
- R3: Chip select stays active through every cycle of a request, including the recovery cycles between write accesses. It is inactive in the cycle that done is high, so requests are separated by at least one clock with chip select inactive.
- R4: With config bit 3 set, the lane strobe of lane k goes low during a write strobe exactly when it carries an enabled request byte. During a read strobe, lane k goes low exactly when it carries a requested byte. Lane k carries byte j when `(aligned access address + k) - req_addr = j` with 0 <= j < S.
- R5: With config bit 3 clear, all lane strobes stay high during reads, and writes drive the lanes as in R4.
- R6: Without extended wait, each read access holds output enable low for the read wait count + 1 cycles, and each write access holds write enable low for the write wait count + 1 cycles.
- R7: With config bit 5 set, the 10-bit extended count replaces both the read and the write wait count.
- R8: With config bit 4 set, every read access after the first within one request uses the page wait count. Writes are unaffected.
- R9: Successive write accesses of one request are separated by one cycle with write enable high. Successive read accesses keep output enable low without a break.
- R10: Done is high for one cycle, the cycle after the last strobe cycle, and the read result is valid in that cycle. The block accepts a new request in the idle state and in the done cycle.
- R11: Reserved config bits [7:6] have no effect on any output.
- R12: After reset, chip select is inactive, output enable, write enable and all lane strobes are high, done is low and a request is accepted.
- R13: Output enable and write enable are never low together, and the lanes above the bank width stay high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg | input | 8 | Bank configuration word |
| wait_rd | input | WW | Read wait count |
| wait_wr | input | WW | Write wait count |
| wait_pg | input | WW | Page-mode follow-on read wait count |
| wait_ext | input | EW | Extended shared wait count |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_addr | input | AW | Byte address |
| req_wdata | input | 32 | Right-aligned write data |
| req_be | input | 4 | Byte enables for request bytes |
| done | output | 1 | Request complete pulse |
| rdata | output | 32 | Assembled read data |
| mem_cs | output | 1 | Chip select, polarity from config |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lane_n | output | 4 | Byte lane strobes, active low |
| mem_addr | output | AW | External byte address |
| mem_wdata | output | 32 | External write data by lane |
| mem_rdata | input | 32 | External read data by lane |

## Verification
A request accepted at a rising edge starts its first strobe cycle right after that edge. With N accesses and wait values w_i, the last strobe cycle ends after the sum of (w_i + 1), plus N - 1 recovery cycles for writes. Done therefore appears at the (sum + recovery + 1)th falling edge after the accepting edge. The bench samples every output on falling edges and counts them from acceptance. It compares that count with the value computed from the mode, size, width and direction. At the same edges it checks lanes, chip select and strobe runs against the per-lane formula, and checks read data and the written memory image in the done cycle.

// File: rtl/sram_bank_ctrl.sv
module sram_bank_ctrl #(
  parameter int AW = 16,
  parameter int WW = 5,
  parameter int EW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    cfg,
  input  logic [WW-1:0] wait_rd,
  input  logic [WW-1:0] wait_wr,
  input  logic [WW-1:0] wait_pg,
  input  logic [EW-1:0] wait_ext,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [1:0]    req_size,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   req_wdata,
  input  logic [3:0]    req_be,
  output logic          done,
  output logic [31:0]   rdata,
  output logic          mem_cs,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [3:0]    mem_lane_n,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata
);
  typedef enum logic [1:0] {S_IDLE, S_ACC, S_REC, S_DONE} st_t;
  st_t st;

  logic          r_write;
  logic [1:0]    r_size;
  logic [AW-1:0] r_addr;
  logic [31:0]   r_wdata;
  logic [3:0]    r_be;
  logic [1:0]    sub;
  logic [EW-1:0] cnt;
  logic [31:0]   rbuf;

  wire [1:0] wlog  = (cfg[1:0] == 2'd0) ? 2'd0 : (cfg[1:0] == 2'd1) ? 2'd1 : 2'd2;
  wire [1:0] slog  = (r_size == 2'd3) ? 2'd2 : r_size;
  wire [1:0] wmask = 2'((3'd1 << wlog) - 3'd1);
  wire [2:0] nsub  = (slog > wlog) ? (3'd1 << (slog - wlog)) : 3'd1;
  wire [1:0] last_sub = 2'(nsub - 3'd1);

  function automatic logic [EW-1:0] wait_sel(input logic wr, input logic [1:0] idx);
    if (!wr && cfg[4] && idx != 2'd0) return EW'(wait_pg);
    else if (cfg[5])                  return wait_ext;
    else if (wr)                      return EW'(wait_wr);
    else                              return EW'(wait_rd);
  endfunction

  logic [3:0] lane_ok;
  logic [1:0] lane_j [4];

  always_comb begin
    int j;
    for (int k = 0; k < 4; k++) begin
      j = (int'(sub) << wlog) + k - int'(r_addr[1:0] & wmask);
      lane_ok[k] = (k < (1 << wlog)) && (j >= 0) && (j < (1 << slog));
      lane_j[k]  = 2'(j);
    end
  end

  always_comb begin
    mem_wdata  = '0;
    mem_lane_n = 4'hF;
    for (int k = 0; k < 4; k++) begin
      if (lane_ok[k]) mem_wdata[8*k +: 8] = r_wdata[8*lane_j[k] +: 8];
      if (st == S_ACC) begin
        if (r_write)     mem_lane_n[k] = ~(lane_ok[k] & r_be[lane_j[k]]);
        else if (cfg[3]) mem_lane_n[k] = ~lane_ok[k];
      end
    end
  end

  wire cs_on = (st == S_ACC) || (st == S_REC);
  assign mem_cs    = cfg[2] ? cs_on : ~cs_on;
  assign mem_oe_n  = !(st == S_ACC && !r_write);
  assign mem_we_n  = !(st == S_ACC && r_write);
  assign mem_addr  = r_addr + (AW'(sub) << wlog);
  assign req_ready = (st == S_IDLE) || (st == S_DONE);
  assign done      = (st == S_DONE);
  assign rdata     = rbuf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; r_write <= 1'b0; r_size <= '0; r_addr <= '0; r_wdata <= '0;
      r_be <= '0; sub <= '0; cnt <= '0; rbuf <= '0;
    end else begin
      case (st)
        S_IDLE, S_DONE: begin
          if (req_valid) begin
            st <= S_ACC; r_write <= req_write; r_size <= req_size; r_addr <= req_addr;
            r_wdata <= req_wdata; r_be <= req_be; sub <= '0; rbuf <= '0;
            cnt <= wait_sel(req_write, 2'd0);
          end else begin
            st <= S_IDLE;
          end
        end
        S_ACC: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else begin
            if (!r_write)
              for (int k = 0; k < 4; k++)
                if (lane_ok[k]) rbuf[8*lane_j[k] +: 8] <= mem_rdata[8*k +: 8];
            if (sub == last_sub) begin
              st <= S_DONE;
            end else begin
              sub <= sub + 2'd1;
              if (r_write) st <= S_REC;
              else         cnt <= wait_sel(1'b0, sub + 2'd1);
            end
          end
        end
        S_REC: begin
          cnt <= wait_sel(1'b1, sub);
          st  <= S_ACC;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module sram_bank_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] cfg,
  input logic       done,
  input logic       mem_cs,
  input logic       mem_oe_n,
  input logic       mem_we_n,
  input logic [3:0] mem_lane_n
);
  wire cs_act = cfg[2] ? mem_cs : !mem_cs;

  p_strobe_excl_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));
  p_upper_lanes8_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[1:0] == 2'd0) |-> (mem_lane_n[3:1] == 3'b111));
  p_upper_lanes16_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[1:0] == 2'd1) |-> (mem_lane_n[3:2] == 2'b11));
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_cs_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cs_act);
  p_quiet_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |-> (mem_oe_n && mem_we_n && mem_lane_n == 4'hF));
  p_mode0_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n && !cfg[3]) |-> (mem_lane_n == 4'hF));
endmodule

bind sram_bank_ctrl sram_bank_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg(cfg), .done(done), .mem_cs(mem_cs),
  .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_lane_n(mem_lane_n)
);

// File: tb/sram_bank_ctrl_tb.sv
module sram_bank_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [7:0]  cfg = 8'h00;
  logic [4:0]  wait_rd = 5'd2, wait_wr = 5'd3, wait_pg = 5'd1;
  logic [9:0]  wait_ext = 10'd6;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]  req_size = '0;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_be = '0;
  logic        req_ready, done, mem_cs, mem_oe_n, mem_we_n;
  logic [31:0] rdata, mem_wdata, mem_rdata;
  logic [3:0]  mem_lane_n;
  logic [15:0] mem_addr;

  sram_bank_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .wait_rd(wait_rd), .wait_wr(wait_wr),
    .wait_pg(wait_pg), .wait_ext(wait_ext), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_be(req_be), .done(done), .rdata(rdata), .mem_cs(mem_cs), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_lane_n(mem_lane_n), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];
  int bw = 1;
  int tests = 0, fails = 0;

  always_comb begin
    mem_rdata = '0;
    for (int k = 0; k < 4; k++)
      if (k < bw) mem_rdata[8*k +: 8] = mem[8'(int'(mem_addr & ~16'(bw - 1)) + k)];
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int wt(input bit wr, input int i, input bit pg, input bit ex, input int rdw);
    if (!wr && pg && i > 0) return int'(wait_pg);
    if (ex) return int'(wait_ext);
    return wr ? int'(wait_wr) : rdw;
  endfunction

  task automatic run_req(input bit wr, input int sz, input int w, input bit cp, input bit lm,
                         input bit pg, input bit ex, input bit res, input int n);
    int s, nacc, t, cnt, lane_bad, cs_bad, both, strokes, al, j;
    bit prev, fin, strobe, cs_on;
    logic [15:0] addr;
    logic [31:0] wd, exp_rd;
    logic [3:0] be, exp_ln;
    string tag;
    s = 1 << sz; bw = 1 << w;
    nacc = (sz > w) ? (1 << (sz - w)) : 1;
    addr = 16'(((n * 4) % 240) + 8 + ((sz == 0) ? (n % 4) : (sz == 1) ? (n % 2) * 2 : 0));
    wd = 32'(n) * 32'h0103_0507 ^ 32'hA5C3_961E;
    be = 4'(n * 7 + 3);
    t = 0;
    for (int i = 0; i < nacc; i++) t += wt(wr, i, pg, ex, int'(wait_rd)) + 1;
    if (wr) t += nacc - 1;
    exp_rd = '0;
    for (int b = 0; b < s; b++) exp_rd[8*b +: 8] = mem[8'(addr) + 8'(b)];
    if (wr) for (int b = 0; b < s; b++) if (be[b]) exp_mem[8'(addr) + 8'(b)] = wd[8*b +: 8];
    tag = res ? "R11" : "R1";

    cfg = {res ? 2'b11 : 2'b00, ex, pg, lm, cp, 2'(w)};
    req_write = wr; req_size = 2'(sz); req_addr = addr; req_wdata = wd; req_be = be;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    cnt = 0; lane_bad = 0; cs_bad = 0; both = 0; strokes = 0; prev = 1'b0; fin = 1'b0;
    while (!fin) begin
      cnt++;
      if (done) begin
        fin = 1'b1;
      end else if (cnt > 400) begin
        fin = 1'b1;
      end else begin
        cs_on = cp ? mem_cs : !mem_cs;
        if (!cs_on) cs_bad++;
        if (!mem_oe_n && !mem_we_n) both++;
        strobe = wr ? !mem_we_n : !mem_oe_n;
        if (strobe && !prev) strokes++;
        prev = strobe;
        exp_ln = 4'hF;
        if (strobe) begin
          al = int'(mem_addr) & ~(bw - 1);
          for (int k = 0; k < 4; k++) begin
            j = al + k - int'(addr);
            if (k < bw && j >= 0 && j < s) begin
              if (wr ? be[j] : lm) exp_ln[k] = 1'b0;
            end
            if (wr && !mem_lane_n[k] && k < bw) mem[8'(al + k)] = mem_wdata[8*k +: 8];
          end
        end
        if (mem_lane_n != exp_ln) lane_bad++;
        @(negedge clk);
      end
    end
    chk(cnt == t + 1, ex ? "R7 latency" : (pg && !wr) ? "R8 latency" : "R6 latency", cnt, t + 1);
    chk(strokes == (wr ? nacc : 1), "R9 strobe runs", strokes, wr ? nacc : 1);
    chk(lane_bad == 0, lm ? "R4 lane strobes" : "R5 lane strobes", lane_bad, 0);
    chk(cs_bad == 0, cp ? "R2 cs held high" : "R3 cs held", cs_bad, 0);
    chk(both == 0, "R13 oe/we overlap", both, 0);
    chk(done && (cp ? !mem_cs : mem_cs) && req_ready, "R10 done/cs gap/ready",
        {done, mem_cs, req_ready}, {1'b1, !cp, 1'b1});
    if (wr) begin
      int bad;
      bad = 0;
      for (int a = 0; a < 256; a++) if (mem[a] != exp_mem[a]) bad++;
      chk(bad == 0, {tag, " write image"}, bad, 0);
    end else begin
      chk(rdata == exp_rd, {tag, " read data"}, rdata, exp_rd);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n;
    for (int a = 0; a < 256; a++) begin
      mem[a] = 8'(a * 7 + 3);
      exp_mem[a] = 8'(a * 7 + 3);
    end
    repeat (3) @(negedge clk);
    chk(mem_cs && mem_oe_n && mem_we_n && mem_lane_n == 4'hF && !done && req_ready,
        "R12 reset state", {mem_cs, mem_oe_n, mem_we_n, mem_lane_n, done, req_ready}, 9'b111111101);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_cs && mem_oe_n && !done && req_ready, "R12 idle after reset",
        {mem_cs, mem_oe_n, done, req_ready}, 4'b1101);
    n = 0;
    for (int pass = 0; pass < 2; pass++) begin
      wait_rd = pass ? 5'd4 : 5'd2;
      for (int w = 0; w < 3; w++)
        for (int sz = 0; sz < 3; sz++)
          for (int wr = 0; wr < 2; wr++)
            for (int m = 0; m < 16; m++) begin
              run_req(wr[0], sz, w, m[0], m[1], m[2], m[3], pass[0], n);
              n++;
            end
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule